// File: doc/BRIEF.md
# Segment table address translator

This block turns a logical address, given as a segment number and an offset, into a physical address. It reads a descriptor for the segment from a table in memory. Two configuration inputs describe that table. The table origin gives its start address in memory. The table size gives how many segment numbers are legal.

A requester hands over one translation at a time through a ready/valid handshake. The block then checks the segment number and reads the two 32-bit words of the descriptor over a request/response memory port. It checks the descriptor and the requested access type. It ends with a one-cycle `done` pulse that carries the physical address and a fault code.

Descriptor layout: word 0 holds the 32-bit segment base. Word 1 holds the following fields:

| Bits | Meaning |
|------|---------|
| [19:0] | segment limit (the segment length) |
| 20 | read permitted |
| 21 | write permitted |
| 22 | execute permitted |
| 31 | descriptor valid |
| 30:23 | reserved, ignored |

The controller is a state machine with six states:
- `ST_IDLE`: ready for a request.
- `ST_BASE_REQ`: issue the read of word 0.
- `ST_BASE_WAIT`: wait for word 0.
- `ST_ATTR_REQ`: issue the read of word 1.
- `ST_ATTR_WAIT`: wait for word 1.
- `ST_DONE`: result presented for one cycle.

Transitions:
- `ST_IDLE` to `ST_DONE` when an accepted segment number is out of range.
- `ST_IDLE` to `ST_BASE_REQ` when an accepted segment number is in range.
- `ST_BASE_REQ` to `ST_BASE_WAIT` on a memory request handshake.
- `ST_BASE_WAIT` to `ST_ATTR_REQ` on a memory response.
- `ST_ATTR_REQ` to `ST_ATTR_WAIT` on a memory request handshake.
- `ST_ATTR_WAIT` to `ST_DONE` on a memory response.
- `ST_DONE` to `ST_IDLE` always.

Top module: `seg_xlate`

## Requirements
- R1: `req_ready` is high only in `ST_IDLE`. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. No new request is accepted until the current one has produced `done`.
- R2: If the segment number is greater than or equal to `cfg_tbl_len`, the block issues no memory read. It raises `done` in the cycle after acceptance with `fault_code` 1. With `cfg_tbl_len` 0, every segment number faults.
- R3: An in-range request issues exactly two reads, in this order: word 0 at `cfg_tbl_base + seg*8`, then word 1 at `cfg_tbl_base + seg*8 + 4`.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and `mem_req_addr` stays unchanged.
- R5: If bit 31 of word 1 is 0, the result is `fault_code` 2 (invalid descriptor).
- R6: If the offset is greater than or equal to the 20-bit limit in word 1 bits [19:0], the result is `fault_code` 3 (limit fault).
- R7: `req_acc` selects the permission bit that must be set in word 1:
  - 0 = read, needs bit 20.
  - 1 = write, needs bit 21.
  - 2 = execute, needs bit 22.
  - 3 has no permission bit and always faults.

  A missing permission gives `fault_code` 4.
- R8: With no fault, `fault_code` is 0 and `phys_addr` is word 0 plus the zero-extended offset, modulo 2^32.
- R9: Fault priority: invalid (2) over limit (3) over protection (4).
- R10: `done` lasts exactly one cycle. `phys_addr` is 0 whenever `fault_code` is nonzero. The result is produced the cycle after the word 1 response.
- R11: During and right after reset, `req_ready` is 1, and `done` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cfg_tbl_base | input | 32 | memory address of the segment table |
| cfg_tbl_len | input | 16 | number of legal segment numbers |
| req_valid | input | 1 | translation request present |
| req_ready | output | 1 | block can accept a request |
| req_seg | input | 16 | segment number |
| req_off | input | 16 | offset within the segment |
| req_acc | input | 2 | access type (0 read, 1 write, 2 execute) |
| mem_req_valid | output | 1 | memory read request |
| mem_req_ready | input | 1 | memory accepts the request |
| mem_req_addr | output | 32 | memory read address |
| mem_rsp_valid | input | 1 | read data present |
| mem_rsp_data | input | 32 | read data |
| done | output | 1 | one-cycle result strobe |
| phys_addr | output | 32 | translated physical address |
| fault_code | output | 3 | 0 none, 1 segment range, 2 invalid, 3 limit, 4 protection |

## Verification
The assertions assume the following about the inputs:
- The memory returns exactly one response for each accepted read, and only while the block is waiting for it.
- `cfg_tbl_base` and `cfg_tbl_len` do not change while a translation is in flight.

The bench memory model answers one cycle after each accepted read and throttles `mem_req_ready` with a fixed pattern. The bench changes the configuration only when the block is idle and nothing is outstanding.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_BASE_REQ  = 3'd1,
        ST_BASE_WAIT = 3'd2,
        ST_ATTR_REQ  = 3'd3,
        ST_ATTR_WAIT = 3'd4,
        ST_DONE      = 3'd5
    } xl_state_t;

    typedef enum logic [2:0] {
        FC_NONE      = 3'd0,
        FC_SEG_RANGE = 3'd1,
        FC_INVALID   = 3'd2,
        FC_LIMIT     = 3'd3,
        FC_PROT      = 3'd4
    } fault_t;

    localparam int PERM_RD_BIT = 20;
    localparam int PERM_WR_BIT = 21;
    localparam int PERM_EX_BIT = 22;
    localparam int VALID_BIT   = 31;

endpackage

// File: rtl/seg_entry_addr.sv
module seg_entry_addr #(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 16
) (
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [SEG_W-1:0]  seg,
    input  logic              word_sel,
    output logic [ADDR_W-1:0] addr
);
    localparam int DESC_SHIFT = 3;   // two 4-byte words per descriptor

    always_comb begin
        addr = tbl_base + (ADDR_W'(seg) << DESC_SHIFT) + (word_sel ? ADDR_W'(4) : '0);
    end
endmodule

// File: rtl/seg_entry_check.sv
module seg_entry_check
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int LIM_W  = 20
) (
    input  logic [ADDR_W-1:0] base_word,
    input  logic [31:0]       attr_word,
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        access,
    output fault_t            code,
    output logic [ADDR_W-1:0] phys
);
    logic             perm_ok;
    logic [LIM_W-1:0] limit;
    logic             unused_rsvd;

    assign limit       = attr_word[LIM_W-1:0];
    assign unused_rsvd = ^attr_word[30:23];

    always_comb begin
        unique case (access)
            2'd0:    perm_ok = attr_word[PERM_RD_BIT];
            2'd1:    perm_ok = attr_word[PERM_WR_BIT];
            2'd2:    perm_ok = attr_word[PERM_EX_BIT];
            default: perm_ok = 1'b0;
        endcase

        if (!attr_word[VALID_BIT])
            code = FC_INVALID;
        else if (LIM_W'(offset) >= limit)
            code = FC_LIMIT;
        else if (!perm_ok)
            code = FC_PROT;
        else
            code = FC_NONE;

        phys = base_word + ADDR_W'(offset);
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int LIM_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_tbl_base,
    input  logic [SEG_W-1:0]  cfg_tbl_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              done,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [2:0]        fault_code
);
    xl_state_t         state_q, state_d;
    logic [SEG_W-1:0]  seg_q;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        acc_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] phys_q;
    fault_t            code_q;
    fault_t            chk_code;
    logic [ADDR_W-1:0] chk_phys;
    logic              accept;
    logic              seg_bad;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign seg_bad = (req_seg >= cfg_tbl_len);

    seg_entry_addr #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_addr (
        .tbl_base (cfg_tbl_base),
        .seg      (seg_q),
        .word_sel (state_q == ST_ATTR_REQ),
        .addr     (mem_req_addr)
    );

    seg_entry_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LIM_W(LIM_W)) u_chk (
        .base_word (base_q),
        .attr_word (mem_rsp_data),
        .offset    (off_q),
        .access    (acc_q),
        .code      (chk_code),
        .phys      (chk_phys)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = seg_bad ? ST_DONE : ST_BASE_REQ;
            ST_BASE_REQ:  if (mem_req_ready) state_d = ST_BASE_WAIT;
            ST_BASE_WAIT: if (mem_rsp_valid) state_d = ST_ATTR_REQ;
            ST_ATTR_REQ:  if (mem_req_ready) state_d = ST_ATTR_WAIT;
            ST_ATTR_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q  <= '0;
            off_q  <= '0;
            acc_q  <= '0;
            base_q <= '0;
            phys_q <= '0;
            code_q <= FC_NONE;
        end else begin
            if (accept) begin
                seg_q <= req_seg;
                off_q <= req_off;
                acc_q <= req_acc;
                if (seg_bad) begin
                    code_q <= FC_SEG_RANGE;
                    phys_q <= '0;
                end
            end
            if (state_q == ST_BASE_WAIT && mem_rsp_valid)
                base_q <= mem_rsp_data;
            if (state_q == ST_ATTR_WAIT && mem_rsp_valid) begin
                code_q <= chk_code;
                phys_q <= (chk_code == FC_NONE) ? chk_phys : '0;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_BASE_REQ) || (state_q == ST_ATTR_REQ);
        done          = (state_q == ST_DONE);
        phys_addr     = phys_q;
        fault_code    = code_q;
    end
endmodule

// File: rtl/seg_xlate_sva.sv
module seg_xlate_sva #(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEG_W-1:0]  cfg_tbl_len,
    input logic              req_valid,
    input logic              req_ready,
    input logic [SEG_W-1:0]  req_seg,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              done,
    input logic [ADDR_W-1:0] phys_addr,
    input logic [2:0]        fault_code
);
    a_r2_range_fault_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_seg >= cfg_tbl_len)) |=>
            (done && fault_code == 3'd1 && !mem_req_valid));

    a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code != 3'd0) |-> (phys_addr == '0));

    a_r1_no_mem_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    a_r1_busy_during_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);
endmodule

bind seg_xlate seg_xlate_sva #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_tbl_len   (cfg_tbl_len),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_seg       (req_seg),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .phys_addr     (phys_addr),
    .fault_code    (fault_code)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;
    localparam logic [31:0] TBASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_tbl_base = TBASE;
    logic [15:0] cfg_tbl_len = 16'd10;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_seg = '0;
    logic [15:0] req_off = '0;
    logic [1:0]  req_acc = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [31:0] phys_addr;
    logic [2:0]  fault_code;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [31:0] phys;
        logic [2:0]  code;
        int          nrd;
        logic [31:0] a0;
    } exp_t;
    exp_t exp_q[$];

    logic [31:0] tmem [0:31];

    always #10 clk = ~clk;

    seg_xlate dut (
        .clk(clk), .rst_n(rst_n), .cfg_tbl_base(cfg_tbl_base), .cfg_tbl_len(cfg_tbl_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
        .req_acc(req_acc), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .phys_addr(phys_addr), .fault_code(fault_code)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic logic [31:0] attr(input bit v, input bit x, input bit w, input bit r, input logic [19:0] lim);
        return {v, 8'h00, x, w, r, lim};
    endfunction

    // memory model: throttled ready, response one cycle after each accepted read
    initial begin
        int          cyc = 0;
        bit          pend = 1'b0;
        logic [31:0] paddr = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = ((paddr - TBASE) < 32'd128) ? tmem[(paddr - TBASE) >> 2] : 32'h0;
                pend = 1'b0;
            end else begin
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 32'hDEAD_BEEF;
            end
            mem_req_ready = (cyc % 3 != 1);
            if (mem_req_valid && mem_req_ready) begin
                pend  = 1'b1;
                paddr = mem_req_addr;
            end
        end
    end

    // driver: computes the expected result and pushes it to the scoreboard
    task automatic send(input logic [15:0] s, input logic [15:0] o, input logic [1:0] a);
        exp_t        e;
        logic [31:0] w1;
        bit          perm;
        e.a0 = TBASE + {13'b0, s, 3'b0};
        if (s >= cfg_tbl_len) begin
            e.code = 3'd1; e.phys = 32'h0; e.nrd = 0;
        end else begin
            e.nrd = 2;
            w1 = tmem[2*s+1];
            case (a)
                2'd0: perm = w1[20];
                2'd1: perm = w1[21];
                2'd2: perm = w1[22];
                default: perm = 1'b0;
            endcase
            if (!w1[31])                   e.code = 3'd2;
            else if ({4'b0, o} >= w1[19:0]) e.code = 3'd3;
            else if (!perm)                e.code = 3'd4;
            else                           e.code = 3'd0;
            e.phys = (e.code == 3'd0) ? tmem[2*s] + {16'b0, o} : 32'h0;
        end
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: collects read addresses and compares results on done
    initial begin
        int          nrd = 0;
        logic [31:0] ra [0:3];
        bit          prev_done = 1'b0;
        bit          prev_stall = 1'b0;
        logic [31:0] prev_addr = '0;
        exp_t        e;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (prev_stall)
                    check(mem_req_valid && mem_req_addr == prev_addr, "R4 held request",
                          mem_req_addr, prev_addr);
                prev_stall = mem_req_valid && !mem_req_ready;
                prev_addr  = mem_req_addr;
                if (mem_req_valid && mem_req_ready) begin
                    if (nrd < 4) ra[nrd] = mem_req_addr;
                    nrd++;
                end
                if (done && prev_done) check(1'b0, "R10 done pulse", 32'd1, 32'd0);
                if (done) begin
                    check(!req_ready, "R1 busy while done", {31'b0, req_ready}, 32'd0);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R1 unexpected done", 32'd1, 32'd0);
                    end else begin
                        e = exp_q.pop_front();
                        check(fault_code == e.code, "R2/R5/R6/R7/R9 fault code",
                              {29'b0, fault_code}, {29'b0, e.code});
                        check(phys_addr == e.phys, "R8/R10 phys addr", phys_addr, e.phys);
                        check(nrd == e.nrd, "R2/R3 read count", nrd, e.nrd);
                        if (e.nrd == 2 && nrd == 2) begin
                            check(ra[0] == e.a0, "R3 word0 addr", ra[0], e.a0);
                            check(ra[1] == e.a0 + 32'd4, "R3 word1 addr", ra[1], e.a0 + 32'd4);
                        end
                    end
                    nrd = 0;
                end
                prev_done = done;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        foreach (tmem[i]) tmem[i] = 32'h0;
        tmem[0]  = 32'h0004_0000; tmem[1]  = attr(1, 1, 1, 1, 20'h00100);
        tmem[2]  = 32'h8000_0000; tmem[3]  = attr(1, 0, 0, 1, 20'h10000);
        tmem[4]  = 32'h0000_5000; tmem[5]  = attr(0, 1, 1, 1, 20'hFFFFF);
        tmem[6]  = 32'h0000_6000; tmem[7]  = attr(1, 0, 1, 0, 20'h00000);
        tmem[8]  = 32'hFFFF_FFF0; tmem[9]  = attr(1, 1, 0, 0, 20'h00020);
        tmem[10] = 32'h0000_A000; tmem[11] = attr(0, 0, 0, 0, 20'h00000);
        tmem[12] = 32'h0000_C000; tmem[13] = attr(1, 0, 0, 0, 20'h00010);
        tmem[18] = 32'h0009_0000; tmem[19] = attr(1, 1, 1, 1, 20'hFFFFF) | 32'h7F80_0000;

        repeat (3) @(negedge clk);
        // R11 reset state
        check(req_ready == 1'b1, "R11 ready in reset", {31'b0, req_ready}, 32'd1);
        check(done == 1'b0, "R11 done in reset", {31'b0, done}, 32'd0);
        check(mem_req_valid == 1'b0, "R11 mem idle in reset", {31'b0, mem_req_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !done, "R11 after reset", {31'b0, req_ready}, 32'd1);

        send(16'd0, 16'h0010, 2'd0);  // R8 read ok
        send(16'd0, 16'h00FF, 2'd1);  // R8 write ok, last legal offset
        send(16'd0, 16'h0100, 2'd2);  // R6 offset equal to limit
        send(16'd1, 16'hFFFF, 2'd0);  // R8 large offset within limit
        send(16'd1, 16'h0004, 2'd1);  // R7 write without permission
        send(16'd1, 16'h0004, 2'd3);  // R7 access code 3
        send(16'd2, 16'h0000, 2'd0);  // R5 invalid descriptor
        send(16'd3, 16'h0000, 2'd1);  // R6 zero limit
        send(16'd4, 16'h001F, 2'd2);  // R8 base wraps, execute ok
        send(16'd4, 16'h0001, 2'd0);  // R7 read on execute-only
        send(16'd5, 16'h0000, 2'd0);  // R9 invalid wins over limit and protection
        send(16'd6, 16'h0020, 2'd0);  // R9 limit wins over protection
        send(16'd6, 16'h0005, 2'd0);  // R7 no permission bits
        send(16'd9, 16'h0003, 2'd1);  // R8 reserved bits ignored
        send(16'd10, 16'h0000, 2'd0); // R2 segment equal to length
        send(16'hFFFF, 16'h0000, 2'd0); // R2 largest segment
        drain();
        cfg_tbl_len = 16'd0;
        send(16'd0, 16'h0000, 2'd0);  // R2 zero-length table
        drain();
        cfg_tbl_len = 16'd10;
        send(16'd0, 16'h0001, 2'd0);
        drain();
        check(exp_q.size() == 0, "R1 all results seen", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule